// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame is kept. Each time `rx_valid` is high it takes the frame identifier, the extended-format flag and the remote-request flag. It compares them against a set of programmable filter banks. One clock later it either raises a push request for one of two receive queues, together with the number of the filter slot that hit, or raises nothing and the frame is dropped.

Each bank holds two 32-bit words plus four control bits: scale, mode, queue and active. A bank can run as one 32-bit identifier/mask filter, two 32-bit exact identifiers, two 16-bit identifier/mask pairs, or four 16-bit exact identifiers. A bank therefore provides one, two or four comparison slots.

Configuration goes through a small write port that addresses banks with a one-hot select. The write port only takes effect while the global `cfg_init` level is high. While `cfg_init` is high, matching is suspended.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, `fifo_req` and `match_idx` are zero, every bank is inactive, and no frame is accepted until banks are programmed and activated.
- R2: Writes take effect only while `cfg_init` is 1. A write with `cfg_init` at 0 changes nothing, including one made in the same cycle as a frame. The write targets every bank whose bit is set in `cfg_bank_sel`. `cfg_field` selects what is written: 0 writes word A, 1 writes word B, 2 writes the control bits. The control bits are `cfg_wdata[0]` scale32, `[1]` list, `[2]` queue 1 and `[3]` active.
- R3: While `cfg_init` is 1, no frame raises a push request.
- R4: The 32-bit compare word of an extended frame is {id[28:0], 1, rtr, 0}. The compare word of a standard frame is {id[10:0], 18 zeros, 0, rtr, 0}.
- R5: In 32-bit mask mode (scale32=1, list=0), word A is the identifier and word B the mask. A mask bit of 1 requires equality and a mask bit of 0 is don't-care. The bank has one slot.
- R6: In 32-bit list mode (scale32=1, list=1), the bank accepts a compare word equal to word A (slot 0) or to word B (slot 1).
- R7: The 16-bit compare value is {word[31:21], rtr, ide, word[20:18]}. In 16-bit mask mode (scale32=0, list=0), each word holds an identifier in bits 31:16 and a mask in bits 15:0. This gives two slots: A then B.
- R8: In 16-bit list mode (scale32=0, list=1), the bank holds four exact 16-bit values. They are checked in slot order A[31:16], A[15:0], B[31:16], B[15:0].
- R9: `fifo_req` is 2'b01 for a bank whose queue bit is 0 and 2'b10 for a bank whose queue bit is 1.
- R10: When several slots match, the lowest bank wins, and inside it the lowest slot wins. `match_idx` is the sum of the slot counts of all lower banks, active or not, plus the slot number.
- R11: A frame that matches no active slot gives `fifo_req` = 0 and `match_idx` = 0. `fifo_req` is one-hot or zero.
- R12: The result appears on the clock edge that samples `rx_valid` and lasts one cycle. With `rx_valid` low, the next cycle shows no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_init | input | 1 | Global filter-init level: enables writes, suspends matching |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank_sel | input | NBANK | One-hot bank select |
| cfg_field | input | 2 | 0 word A, 1 word B, 2 control |
| cfg_wdata | input | 32 | Write data |
| rx_valid | input | 1 | Frame identifier strobe |
| rx_id | input | 29 | Identifier; standard frames use bits 10:0 |
| rx_ext | input | 1 | Extended-format frame |
| rx_rtr | input | 1 | Remote-request frame |
| fifo_req | output | 2 | Push request for queue 0 (bit 0) or queue 1 (bit 1) |
| match_idx | output | SLOTW | Index of the slot that hit |

## Verification
A configuration write and a frame strobe can land in the same cycle. The bench provokes this by asserting `cfg_we` with `cfg_init` low, together with a frame that the current setup accepts. The frame must be judged against the old setup, and a repeat of the same frame on its own must give the same index and queue. A second overlap is one frame hitting slots in two banks at once: a standard identifier is placed inside both a 16-bit mask range and a 16-bit list entry of the next bank, and the lower bank's index is expected. Removing the lower bank from service then shows that the index still counts that bank's slots.

// File: rtl/can_accept_filter.sv
module can_accept_filter #(
  parameter int NBANK = 4,
  parameter int SLOTW = $clog2(4 * NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_init,
  input  logic             cfg_we,
  input  logic [NBANK-1:0] cfg_bank_sel,
  input  logic [1:0]       cfg_field,
  input  logic [31:0]      cfg_wdata,
  input  logic             rx_valid,
  input  logic [28:0]      rx_id,
  input  logic             rx_ext,
  input  logic             rx_rtr,
  output logic [1:0]       fifo_req,
  output logic [SLOTW-1:0] match_idx
);

  logic [NBANK-1:0][31:0] word_a, word_b;
  logic [NBANK-1:0]       scale32, listm, fifo1, active;
  logic [NBANK-1:0][3:0]  bank_hit;
  logic [NBANK-1:0][2:0]  bank_n;
  logic [31:0]            cmp32;
  logic [15:0]            cmp16;
  logic                   found, found_q1;
  logic [SLOTW-1:0]       hit_idx;

  function automatic logic [3:0] slot_hits(input logic [31:0] a, input logic [31:0] b,
                                           input logic sc, input logic ls,
                                           input logic [31:0] c32, input logic [15:0] c16);
    case ({sc, ls})
      2'b10:   slot_hits = {3'b000, ((c32 ^ a) & b) == 32'd0};
      2'b11:   slot_hits = {2'b00, c32 == b, c32 == a};
      2'b00:   slot_hits = {2'b00, ((c16 ^ b[31:16]) & b[15:0]) == 16'd0,
                                   ((c16 ^ a[31:16]) & a[15:0]) == 16'd0};
      default: slot_hits = {c16 == b[15:0], c16 == b[31:16], c16 == a[15:0], c16 == a[31:16]};
    endcase
  endfunction

  function automatic logic [2:0] slot_count(input logic sc, input logic ls);
    case ({sc, ls})
      2'b10:   slot_count = 3'd1;
      2'b01:   slot_count = 3'd4;
      default: slot_count = 3'd2;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_a  <= '0;
      word_b  <= '0;
      scale32 <= '0;
      listm   <= '0;
      fifo1   <= '0;
      active  <= '0;
    end else if (cfg_init && cfg_we) begin
      for (int b = 0; b < NBANK; b++) begin
        if (cfg_bank_sel[b]) begin
          case (cfg_field)
            2'd0: word_a[b] <= cfg_wdata;
            2'd1: word_b[b] <= cfg_wdata;
            2'd2: {active[b], fifo1[b], listm[b], scale32[b]} <= cfg_wdata[3:0];
            default: ;
          endcase
        end
      end
    end
  end

  assign cmp32 = rx_ext ? {rx_id, 1'b1, rx_rtr, 1'b0}
                        : {rx_id[10:0], 18'd0, 1'b0, rx_rtr, 1'b0};
  assign cmp16 = {cmp32[31:21], cmp32[1], cmp32[2], cmp32[20:18]};

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign bank_hit[g] = slot_hits(word_a[g], word_b[g], scale32[g], listm[g], cmp32, cmp16);
    assign bank_n[g]   = slot_count(scale32[g], listm[g]);
  end

  logic sel_q1;
  always_comb begin
    int base;
    found   = 1'b0;
    sel_q1  = 1'b0;
    hit_idx = '0;
    base    = 0;
    for (int b = 0; b < NBANK; b++) begin
      for (int s = 0; s < 4; s++) begin
        if (!found && active[b] && s < int'(bank_n[b]) && bank_hit[b][s]) begin
          found   = 1'b1;
          sel_q1  = fifo1[b];
          hit_idx = SLOTW'(base + s);
        end
      end
      base = base + int'(bank_n[b]);
    end
  end

  assign found_q1 = rx_valid && !cfg_init && found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_req  <= 2'b00;
      match_idx <= '0;
    end else begin
      fifo_req  <= found_q1 ? (sel_q1 ? 2'b10 : 2'b01) : 2'b00;
      match_idx <= found_q1 ? hit_idx : '0;
    end
  end

endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk #(
  parameter int NBANK = 4,
  parameter int SLOTW = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_init,
  input logic                   rx_valid,
  input logic [1:0]             fifo_req,
  input logic [SLOTW-1:0]       match_idx,
  input logic [NBANK-1:0][31:0] word_a,
  input logic [NBANK-1:0][31:0] word_b,
  input logic [4*NBANK-1:0]     ctl
);

  assert_req_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fifo_req));

  assert_idx_zero_on_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_req == 2'b00 |-> match_idx == '0);

  assert_single_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> fifo_req == 2'b00);

  assert_init_suspends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_init |=> fifo_req == 2'b00);

  assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_init |=> $stable(word_a) && $stable(word_b) && $stable(ctl));

endmodule

bind can_accept_filter can_accept_filter_chk #(.NBANK(NBANK), .SLOTW(SLOTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_init(cfg_init), .rx_valid(rx_valid),
  .fifo_req(fifo_req), .match_idx(match_idx), .word_a(word_a), .word_b(word_b),
  .ctl({active, fifo1, listm, scale32})
);

// File: tb/test_can_accept_filter.sv
module test_can_accept_filter;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int SW = 4;

  logic clk = 1'b0, rst_n = 1'b0, cfg_init = 1'b0, cfg_we = 1'b0;
  logic [NB-1:0] cfg_bank_sel = '0;
  logic [1:0] cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic rx_valid = 1'b0, rx_ext = 1'b0, rx_rtr = 1'b0;
  logic [28:0] rx_id = '0;
  logic [1:0] fifo_req;
  logic [SW-1:0] match_idx;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_accept_filter #(.NBANK(NB)) i_can_accept_filter (
    .clk(clk), .rst_n(rst_n), .cfg_init(cfg_init), .cfg_we(cfg_we),
    .cfg_bank_sel(cfg_bank_sel), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .rx_valid(rx_valid), .rx_id(rx_id), .rx_ext(rx_ext), .rx_rtr(rx_rtr),
    .fifo_req(fifo_req), .match_idx(match_idx));

  // {id, ext, rtr, expected fifo_req, expected match_idx}
  localparam logic [36:0] VEC [14] = '{
    {29'h00ABC123, 1'b1, 1'b0, 2'b01, 4'd0},
    {29'h00ABC123, 1'b1, 1'b1, 2'b00, 4'd0},
    {29'h00ABD000, 1'b1, 1'b0, 2'b00, 4'd0},
    {29'h00000123, 1'b0, 1'b0, 2'b10, 4'd1},
    {29'h00000456, 1'b0, 1'b1, 2'b10, 4'd2},
    {29'h00000456, 1'b0, 1'b0, 2'b00, 4'd0},
    {29'h0000070A, 1'b0, 1'b1, 2'b10, 4'd3},
    {29'h0157FFFF, 1'b1, 1'b1, 2'b10, 4'd4},
    {29'h00000100, 1'b0, 1'b0, 2'b01, 4'd5},
    {29'h00000101, 1'b0, 1'b1, 2'b01, 4'd6},
    {29'h00000101, 1'b0, 1'b0, 2'b00, 4'd0},
    {29'h00000102, 1'b0, 1'b0, 2'b01, 4'd7},
    {29'h00000705, 1'b0, 1'b0, 2'b10, 4'd3},
    {29'h1C280000, 1'b1, 1'b0, 2'b00, 4'd0}
  };

  function automatic logic [31:0] ctl(input logic sc, input logic ls, input logic q1, input logic act);
    return {28'd0, act, q1, ls, sc};
  endfunction

  task automatic check(input string req, input logic [1:0] exp_req, input logic [SW-1:0] exp_idx);
    checks++;
    if (fifo_req !== exp_req || match_idx !== exp_idx) begin
      fails++;
      $display("FAIL %s: got req=%b idx=%0d, expected req=%b idx=%0d",
               req, fifo_req, match_idx, exp_req, exp_idx);
    end
  endtask

  task automatic wr(input int bank, input logic [1:0] fld, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank_sel = NB'(1) << bank; cfg_field = fld; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [28:0] id, input logic ext, input logic rtr);
    @(negedge clk);
    rx_valid = 1'b1; rx_id = id; rx_ext = ext; rx_rtr = rtr;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got run still active, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset outputs", 2'b00, 4'd0);
    send(29'h123, 1'b0, 1'b0);
    check("R1 inactive after reset", 2'b00, 4'd0);

    // R2: match-all bank written while init is low must not take
    wr(0, 2'd2, ctl(1'b1, 1'b0, 1'b0, 1'b1));
    send(29'h123, 1'b0, 1'b0);
    check("R2 write ignored without init", 2'b00, 4'd0);

    @(negedge clk); cfg_init = 1'b1;
    wr(0, 2'd0, {29'h00ABC000, 3'b100});
    wr(0, 2'd1, {29'h1FFFF000, 3'b110});
    wr(0, 2'd2, ctl(1'b1, 1'b0, 1'b0, 1'b1));
    wr(1, 2'd0, {11'h123, 21'd0});
    wr(1, 2'd1, {11'h456, 18'd0, 3'b010});
    wr(1, 2'd2, ctl(1'b1, 1'b1, 1'b1, 1'b1));
    wr(2, 2'd0, 32'hE000_FE08);
    wr(2, 2'd1, 32'h0AA8_FFE8);
    wr(2, 2'd2, ctl(1'b0, 1'b0, 1'b1, 1'b1));
    wr(3, 2'd0, 32'h2000_2030);
    wr(3, 2'd1, 32'h2040_E0A0);
    wr(3, 2'd2, ctl(1'b0, 1'b1, 1'b0, 1'b1));
    send(29'h123, 1'b0, 1'b0);
    check("R3 matching suspended in init", 2'b00, 4'd0);
    @(negedge clk); cfg_init = 1'b0;

    // R4..R11 vectors
    for (int i = 0; i < 14; i++) begin
      send(VEC[i][36:8], VEC[i][7], VEC[i][6]);
      check($sformatf("R4-R11 vector %0d (R5 R6 R7 R8 R9 R10)", i), VEC[i][5:4], VEC[i][3:0]);
    end

    // R12: one-cycle result
    send(29'h100, 1'b0, 1'b0);
    check("R12 result cycle", 2'b01, 4'd5);
    @(negedge clk);
    check("R12 pulse ends", 2'b00, 4'd0);

    // R2: write attempt in the same cycle as a frame
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank_sel = 4'b0010; cfg_field = 2'd0; cfg_wdata = 32'd0;
    rx_valid = 1'b1; rx_id = 29'h123; rx_ext = 1'b0; rx_rtr = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; rx_valid = 1'b0;
    check("R2 same-cycle write and frame", 2'b10, 4'd1);
    send(29'h123, 1'b0, 1'b0);
    check("R2 setup unchanged after write", 2'b10, 4'd1);

    // R10: deactivated lower bank still counts its slots
    @(negedge clk); cfg_init = 1'b1;
    wr(2, 2'd2, ctl(1'b0, 1'b0, 1'b1, 1'b0));
    @(negedge clk); cfg_init = 1'b0;
    send(29'h705, 1'b0, 1'b0);
    check("R10 index skips inactive bank slots", 2'b01, 4'd8);
    send(29'h70A, 1'b0, 1'b1);
    check("R11 inactive bank drops frame", 2'b00, 4'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule